// File: doc/BRIEF.md
# Write-Path Fault Status Recorder

This block sits beside an I/O bus master and watches the transactions it issues. When a transaction ends in an error, it records what went wrong and for which transaction. There are three kinds of failure. A transaction can be answered with an error acknowledge. A write can stay unanswered for longer than a fixed time. The bus can also report an error after the transaction has already finished. The first failure fixes the transaction's size, privilege mode, direction and address in a status word and a fault address register. Any failure after that, up to the next clear, only raises a flag that says more than one failure happened.

Only one transaction is tracked at a time. A start pulse latches the transaction's attributes, and a normal or error acknowledge ends the transaction. For writes, a cycle counter runs from the start pulse and raises a timeout if no acknowledge arrives within `TIMEOUT_CYC` cycles. At 25 MHz, 320 cycles is 12.8 µs. Software reads the status word, then writes a one in the summary position to clear it.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset, `status_o` reads 0x0080_0000 and `fault_addr_o` reads 0.
- R2: Bits 23:20 of `status_o` read 0x8 in every cycle, including right after a clear.
- R3: An error acknowledge during an outstanding transaction sets bit 28. On a first error it also sets bit 17 (address valid) and captures the size into bits 27:25 and supervisor mode into bit 24. Bit 18 becomes 1 when the transaction was a read. The address goes to `fault_addr_o`.
- R4: For a write started at clock edge k, an acknowledge sampled at any edge up to and including k+TIMEOUT_CYC prevents a timeout. If no acknowledge has been sampled by then, bit 29 is set at edge k+TIMEOUT_CYC.
- R5: A new start restarts the timeout count. Reads never time out.
- R6: A one-cycle `late_err_i` pulse sets bit 30. It carries the attributes of the most recently started transaction, even one that has already been acknowledged.
- R7: Once bit 17 is set, later errors before a clear set only bit 19. Bits 30:24, bit 18 and `fault_addr_o` stay unchanged.
- R8: A register write (`clr_wr_i`=1) with `clr_bit_i`=1 returns `status_o` to 0x0080_0000 and leaves `fault_addr_o` as it was. A write with `clr_bit_i`=0 changes nothing.
- R9: An error and a clear in the same cycle record that error as a new first error, with bit 19 at 0.
- R10: An acknowledge or error acknowledge while no transaction is outstanding has no effect.
- R11: Bit 31 is set exactly when any of bits 30:28 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xfer_start_i | input | 1 | Transaction start pulse; attributes are latched with it |
| xfer_write_i | input | 1 | 1 = write, 0 = read |
| xfer_size_i | input | 3 | Transaction size code |
| xfer_super_i | input | 1 | Issuer is in supervisor mode |
| xfer_addr_i | input | ADDR_W | Transaction address |
| xfer_ack_i | input | 1 | Normal acknowledge |
| xfer_err_ack_i | input | 1 | Error acknowledge (also ends the transaction) |
| late_err_i | input | 1 | Error reported after the transaction ended |
| clr_wr_i | input | 1 | Status register write strobe |
| clr_bit_i | input | 1 | Value written to the summary bit position |
| status_o | output | 32 | Fault status word |
| fault_addr_o | output | ADDR_W | Captured fault address |

## Verification
Some properties are checked by assertions on every cycle: the reserved field never changes, the summary bit agrees with the valid flag, and the multiple flag never appears without a valid capture. They also check that a captured address is held until a clear, that a clear with no error empties the word, and that the timer never counts past its limit. Other behaviour depends on sequences of inputs, so only the bench scenarios can show it. This covers timeout placement against the acknowledge edge, restarts, reads that never time out, and late errors that pick up a finished transaction's attributes. It also covers acknowledges arriving while the block is idle and a clear that lands together with an error. A behavioural reference model is compared against the outputs on every cycle.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
   localparam int STAT_W  = 32;
   localparam int ERR_BIT = 31;
   localparam int LE_BIT  = 30;
   localparam int TO_BIT  = 29;
   localparam int BE_BIT  = 28;
   localparam int SZ_LSB  = 25;
   localparam int SUP_BIT = 24;
   localparam int RSV_LSB = 20;
   localparam int ME_BIT  = 19;
   localparam int RD_BIT  = 18;
   localparam int FAV_BIT = 17;
   localparam logic [3:0] RSV_VAL = 4'h8;

   typedef struct packed {
      logic late;
      logic tmo;
      logic eack;
   } err_flags_t;

   typedef struct packed {
      logic [2:0] size;
      logic       sup;
      logic       wr;
   } xact_attr_t;
endpackage

// File: rtl/bfc_write_timer.sv
module bfc_write_timer #(
   parameter int TIMEOUT_CYC = 320
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic is_wr_i,
   input  logic done_i,
   output logic expire_o
);
   localparam int CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

   logic          run_q;
   logic [CW-1:0] cnt_q;

   assign expire_o = run_q && !done_i && (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start_i) begin
         run_q <= is_wr_i;
         cnt_q <= '0;
      end else if (run_q) begin
         if (done_i || expire_o) run_q <= 1'b0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4
   no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/bfc_xact_track.sv
module bfc_xact_track
   import bfc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  xact_attr_t        attr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              done_i,
   input  logic              tmo_i,
   output xact_attr_t        attr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              active_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         active_o <= 1'b0;
         attr_o   <= '0;
         addr_o   <= '0;
      end else if (start_i) begin
         active_o <= 1'b1;
         attr_o   <= attr_i;
         addr_o   <= addr_i;
      end else if (active_o && (done_i || tmo_i)) begin
         active_o <= 1'b0;
      end
   end
endmodule

// File: rtl/bfc_fault_log.sv
module bfc_fault_log
   import bfc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  err_flags_t        ev_i,
   input  logic              clr_i,
   input  xact_attr_t        attr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [STAT_W-1:0] status_o,
   output logic [ADDR_W-1:0] fault_addr_o
);
   err_flags_t flg_q;
   xact_attr_t cap_q;
   logic       me_q;
   logic       fav_q;
   logic       any_ev;
   logic       fresh;

   assign any_ev = |ev_i;
   assign fresh  = !fav_q || clr_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flg_q        <= '0;
         cap_q        <= '0;
         me_q         <= 1'b0;
         fav_q        <= 1'b0;
         fault_addr_o <= '0;
      end else if (any_ev) begin
         if (fresh) begin
            flg_q        <= ev_i;
            cap_q        <= attr_i;
            me_q         <= 1'b0;
            fav_q        <= 1'b1;
            fault_addr_o <= addr_i;
         end else begin
            me_q <= 1'b1;
         end
      end else if (clr_i) begin
         flg_q <= '0;
         cap_q <= '0;
         me_q  <= 1'b0;
         fav_q <= 1'b0;
      end
   end

   always_comb begin
      status_o                           = '0;
      status_o[ERR_BIT]                  = |flg_q;
      status_o[LE_BIT]                   = flg_q.late;
      status_o[TO_BIT]                   = flg_q.tmo;
      status_o[BE_BIT]                   = flg_q.eack;
      status_o[SZ_LSB+2:SZ_LSB]          = fav_q ? cap_q.size : 3'd0;
      status_o[SUP_BIT]                  = fav_q && cap_q.sup;
      status_o[RSV_LSB+3:RSV_LSB]        = RSV_VAL;
      status_o[ME_BIT]                   = me_q;
      status_o[RD_BIT]                   = fav_q && !cap_q.wr;
      status_o[FAV_BIT]                  = fav_q;
   end

   // R2
   rsv_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[RSV_LSB+3:RSV_LSB] == RSV_VAL);
   // R11
   summary_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[ERR_BIT] == status_o[FAV_BIT]);
   // R7
   me_needs_fav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[ME_BIT] |-> status_o[FAV_BIT]);
   // R7
   capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[FAV_BIT] && !clr_i) |=> $stable(fault_addr_o));
   // R8
   clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !any_ev) |=> (status_o == {8'h00, RSV_VAL, 20'h0}));
   // R9
   clear_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && any_ev) |=> (!status_o[ME_BIT] && status_o[FAV_BIT]));
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
   import bfc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int TIMEOUT_CYC = 320
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              xfer_start_i,
   input  logic              xfer_write_i,
   input  logic [2:0]        xfer_size_i,
   input  logic              xfer_super_i,
   input  logic [ADDR_W-1:0] xfer_addr_i,
   input  logic              xfer_ack_i,
   input  logic              xfer_err_ack_i,
   input  logic              late_err_i,
   input  logic              clr_wr_i,
   input  logic              clr_bit_i,
   output logic [31:0]       status_o,
   output logic [ADDR_W-1:0] fault_addr_o
);
   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
      $error("bus_fault_capture: ADDR_W out of range");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("bus_fault_capture: TIMEOUT_CYC must be at least 2");
   end

   xact_attr_t        in_attr;
   xact_attr_t        cur_attr;
   logic [ADDR_W-1:0] cur_addr;
   logic              active;
   logic              done;
   logic              tmo;
   err_flags_t        ev;

   assign in_attr = '{size: xfer_size_i, sup: xfer_super_i, wr: xfer_write_i};
   assign done    = xfer_ack_i || xfer_err_ack_i;
   assign ev      = '{late: late_err_i, tmo: tmo, eack: active && xfer_err_ack_i};

   bfc_xact_track #(.ADDR_W(ADDR_W)) track_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (xfer_start_i),
      .attr_i   (in_attr),
      .addr_i   (xfer_addr_i),
      .done_i   (done),
      .tmo_i    (tmo),
      .attr_o   (cur_attr),
      .addr_o   (cur_addr),
      .active_o (active)
   );

   bfc_write_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (xfer_start_i),
      .is_wr_i  (xfer_write_i),
      .done_i   (done),
      .expire_o (tmo)
   );

   bfc_fault_log #(.ADDR_W(ADDR_W)) log_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ev_i         (ev),
      .clr_i        (clr_wr_i && clr_bit_i),
      .attr_i       (cur_attr),
      .addr_i       (cur_addr),
      .status_o     (status_o),
      .fault_addr_o (fault_addr_o)
   );

   // R5
   tmo_only_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo |-> (active && cur_attr.wr));
endmodule

// File: tb/bus_fault_capture_tb_top.sv
`timescale 1ns/1ps
module bus_fault_capture_tb_top;
   localparam int AW = 32;
   localparam int T  = 320;
   localparam logic [31:0] RSV = 32'h0080_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 0, wr = 0, sup = 0, ack = 0, eack = 0, late = 0, cwr = 0, cbit = 0;
   logic [2:0] size = '0;
   logic [AW-1:0] addr = '0;
   logic [31:0] status;
   logic [AW-1:0] faddr;

   int total = 0;
   int bad = 0;
   bit fin = 0;

   always #2 clk = ~clk;

   bus_fault_capture #(.ADDR_W(AW), .TIMEOUT_CYC(T)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .xfer_start_i(start), .xfer_write_i(wr),
      .xfer_size_i(size), .xfer_super_i(sup), .xfer_addr_i(addr),
      .xfer_ack_i(ack), .xfer_err_ack_i(eack), .late_err_i(late),
      .clr_wr_i(cwr), .clr_bit_i(cbit), .status_o(status), .fault_addr_o(faddr));

   // behavioural reference model
   bit m_act, m_run, m_le, m_to, m_be, m_me, m_fav, m_rd, m_sup, x_wr, x_sup;
   int m_cnt, m_size, x_size;
   logic [AW-1:0] m_addr, x_addr;

   always @(posedge clk) begin
      bit dn, te, be, anyev, clr;
      if (!rst_n) begin
         m_act = 0; m_run = 0; m_cnt = 0; m_le = 0; m_to = 0; m_be = 0; m_me = 0;
         m_fav = 0; m_rd = 0; m_sup = 0; m_size = 0; m_addr = '0;
         x_wr = 0; x_sup = 0; x_size = 0; x_addr = '0;
      end else begin
         dn = ack || eack;
         te = m_run && !dn && (m_cnt == T - 1);
         be = m_act && eack;
         anyev = te || be || late;
         clr = cwr && cbit;
         if (anyev) begin
            if (!m_fav || clr) begin
               m_le = late; m_to = te; m_be = be; m_me = 0; m_fav = 1;
               m_size = x_size; m_sup = x_sup; m_rd = !x_wr; m_addr = x_addr;
            end else m_me = 1;
         end else if (clr) begin
            m_le = 0; m_to = 0; m_be = 0; m_me = 0; m_fav = 0;
            m_size = 0; m_sup = 0; m_rd = 0;
         end
         if (start) begin
            x_wr = wr; x_sup = sup; x_size = int'(size); x_addr = addr;
            m_act = 1; m_run = wr; m_cnt = 0;
         end else begin
            if (m_act && (dn || te)) m_act = 0;
            if (m_run) begin
               if (dn || te) m_run = 0;
               else m_cnt++;
            end
         end
      end
   end

   function automatic logic [31:0] model_status();
      logic [31:0] s;
      s = RSV;
      s[31] = m_le || m_to || m_be;
      s[30] = m_le; s[29] = m_to; s[28] = m_be;
      s[27:25] = 3'(m_size); s[24] = m_sup;
      s[19] = m_me; s[18] = m_rd; s[17] = m_fav;
      return s;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         total++;
         if (status !== model_status() || faddr !== m_addr) begin
            bad++;
            $display("FAIL R11 model compare: status=%h addr=%h expected status=%h addr=%h",
                     status, faddr, model_status(), m_addr);
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic go(input logic w, input logic [2:0] sz, input logic s, input logic [AW-1:0] a);
      start = 1; wr = w; size = sz; sup = s; addr = a;
      step(1);
      start = 0;
   endtask

   task automatic clear_all();
      cwr = 1; cbit = 1; step(1); cwr = 0; cbit = 0;
   endtask

   function automatic logic [31:0] st(input bit le, input bit to, input bit be,
                                      input int sz, input bit s, input bit me, input bit rd);
      logic [31:0] v;
      v = RSV | 32'h0002_0000;
      v[31] = le || to || be; v[30] = le; v[29] = to; v[28] = be;
      v[27:25] = 3'(sz); v[24] = s; v[19] = me; v[18] = rd;
      return v;
   endfunction

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      chk("R1 reset status", status, RSV);
      chk("R1 reset addr", faddr, '0);

      // R3 error acknowledge on a read
      go(0, 3'd3, 1, 32'h1234_5000);
      eack = 1; step(1); eack = 0;
      chk("R3 eack status", status, st(0, 0, 1, 3, 1, 0, 1));
      chk("R3 eack addr", faddr, 32'h1234_5000);
      chk("R11 summary", {31'd0, status[31]}, {31'd0, |status[30:28]});

      // R7 later error only flags multiple
      go(1, 3'd1, 0, 32'hAAAA_0000);
      late = 1; step(1); late = 0;
      chk("R7 multiple status", status, st(0, 0, 1, 3, 1, 1, 1));
      chk("R7 addr held", faddr, 32'h1234_5000);
      ack = 1; step(1); ack = 0;

      // R8 write with bit 0 does nothing, bit 1 clears
      cwr = 1; cbit = 0; step(1); cwr = 0;
      chk("R8 no-op write", status, st(0, 0, 1, 3, 1, 1, 1));
      clear_all();
      chk("R8 cleared", status, RSV);
      chk("R8 addr kept", faddr, 32'h1234_5000);
      chk("R2 reserved after clear", {28'd0, status[23:20]}, 32'h8);

      // R4 ack exactly at the limit edge
      go(1, 3'd2, 0, 32'h0000_4400);
      step(T - 1);
      ack = 1; step(1); ack = 0;
      step(5);
      chk("R4 ack at limit", status, RSV);

      // R4 no ack -> timeout at edge k+T
      go(1, 3'd2, 0, 32'h0000_8800);
      step(T - 1);
      chk("R4 not early", status, RSV);
      step(1);
      chk("R4 timeout", status, st(0, 1, 0, 2, 0, 0, 0));
      chk("R4 timeout addr", faddr, 32'h0000_8800);
      clear_all();

      // R5 restart and read immunity
      go(1, 3'd5, 1, 32'h0000_1000);
      step(T - 3);
      go(1, 3'd6, 1, 32'h0000_2000);
      step(T - 1);
      chk("R5 restart not early", status, RSV);
      step(1);
      chk("R5 restart timeout", status, st(0, 1, 0, 6, 1, 0, 0));
      clear_all();
      go(0, 3'd4, 0, 32'h0000_3000);
      step(T + 5);
      chk("R5 read never times out", status, RSV);
      ack = 1; step(1); ack = 0;

      // R10 stray acknowledges ignored
      eack = 1; step(1); eack = 0;
      ack = 1; step(1); ack = 0;
      chk("R10 idle eack ignored", status, RSV);

      // R6 late error after completed write
      go(1, 3'd1, 1, 32'hC0DE_0000);
      ack = 1; step(1); ack = 0;
      step(2);
      late = 1; step(1); late = 0;
      chk("R6 late status", status, st(1, 0, 0, 1, 1, 0, 0));
      chk("R6 late addr", faddr, 32'hC0DE_0000);

      // R9 error with clear in same cycle
      late = 1; step(1); late = 0;
      chk("R9 pre multiple", {31'd0, status[19]}, 32'd1);
      go(0, 3'd7, 0, 32'hBEEF_0000);
      eack = 1; cwr = 1; cbit = 1; step(1); eack = 0; cwr = 0; cbit = 0;
      chk("R9 fresh capture", status, st(0, 0, 1, 7, 0, 0, 1));
      chk("R9 fresh addr", faddr, 32'hBEEF_0000);

      step(2);
      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         fin = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired before the sequence completed");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule